// File: doc/BRIEF.md
# CAS-Latency Read Return Aligner

This block produces the read-return timing for a synchronous DRAM controller or for a behavioural DRAM responder. It takes a per-cycle read strobe, a burst-length code and a three-bit latency code taken from mode-register bits 6..4. For each read it emits one data-valid beat per clock for the length of the burst, delayed by the programmed latency. It also emits an output-drive enable that rises one cycle before the first valid beat and stays high across contiguous beats. Data storage and column address generation sit outside the block. A beat index goes out with each valid beat, so a neighbouring block can pick the column.

The latency can be changed at run time between two and three clocks. The latency code is expected to hold steady while a read is in flight. A read strobe is accepted in every cycle. A new strobe ends any burst still being expanded and starts a fresh beat sequence, which gives fully random column access with a new column on every clock. A reserved latency code raises an error flag and the block then runs with a latency of three.

Top module: `rd_cas_aligner`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, drive_en_o, data_valid_o and lat_err_o (for latency code 010) are 0 and beat_idx_o is 0.
- R2: Latency code 010 selects latency 2. If rd_issue_i is sampled high at rising edge n, data_valid_o with beat_idx_o = 0 is seen by a receiver sampling at edge n+2, so it is driven from edge n+1.
- R3: Latency code 011 selects latency 3. The first valid beat is seen at edge n+3, so it is driven from edge n+2.
- R4: lat_err_o is high exactly when cas_code_i is neither 010 nor 011. With such a reserved code the block times its output as for latency 3.
- R5: Burst code blen_code_i selects 1, 2, 4 or 8 beats for codes 00, 01, 10 and 11. A read gives that many consecutive cycles of data_valid_o, with beat_idx_o counting 0, 1, 2 and so on.
- R6: drive_en_o goes high one cycle before the first valid beat of a group. It is high in every cycle in which data_valid_o is high, and it is low when no valid beat is current or due in the next cycle.
- R7: A read strobe is accepted in every cycle. A strobe that arrives during a burst restarts beat_idx_o at 0 from that strobe, and the remaining beats of the earlier burst are dropped.
- R8: When reads follow each other with no gap in their beats, drive_en_o stays high without a break. It falls in the cycle after the last valid beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_issue_i | input | 1 | Read command registered this cycle |
| blen_code_i | input | 2 | Burst length code: 00=1, 01=2, 10=4, 11=8 beats |
| cas_code_i | input | 3 | Latency field: 010=2, 011=3, other values reserved |
| drive_en_o | output | 1 | Output driver enable, leads the data by one cycle |
| data_valid_o | output | 1 | Read data valid strobe for the current beat |
| beat_idx_o | output | 3 | Position of the current beat within its burst |
| lat_err_o | output | 1 | Reserved latency code in use |

## Verification
The bench applies read patterns and compares them against a cycle model built from the requirements:
- A lone single-beat read at latency 2 pins the exact output edge.
- A four-beat read at latency 3 and a two-beat read under a reserved code confirm the one-cycle shift and the fallback.
- An eight-beat burst exercises the full index count.
- A strobe held high in every cycle separates the restart-on-new-read behaviour from finishing the earlier burst.
- Strobes spaced exactly one burst apart show that the drive enable stays high across bursts.
- Two widely spaced reads show that it drops between groups.

A sweep over all eight latency codes tells the two legal codes apart from the reserved ones.

// File: rtl/rd_align_pkg.sv
package rd_align_pkg;
  localparam int BLEN_CODE_W = 2;
  localparam int LAT_CODE_W  = 3;
  localparam int LAT_MIN     = 2;
  localparam int LAT_MAX     = 3;

  // beats - 1 for a log2 burst code
  function automatic int blen_last(input int code);
    return (1 << code) - 1;
  endfunction
endpackage

// File: rtl/rd_lat_decode.sv
module rd_lat_decode #(
  parameter int CODE_W  = 3,
  parameter int LAT_MIN = 2,
  parameter int LAT_MAX = 3
) (
  input  logic [CODE_W-1:0] cas_code_i,
  output logic [CODE_W-1:0] lat_o,
  output logic              err_o
);
  // legal codes encode the latency value directly
  always_comb begin
    if (int'(cas_code_i) >= LAT_MIN && int'(cas_code_i) <= LAT_MAX) begin
      lat_o = cas_code_i;
      err_o = 1'b0;
    end else begin
      lat_o = CODE_W'(LAT_MAX);
      err_o = 1'b1;
    end
  end
endmodule

// File: rtl/rd_burst_gen.sv
module rd_burst_gen #(
  parameter int CODE_W = 2,
  parameter int IDX_W  = (1 << CODE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [CODE_W-1:0] blen_code_i,
  output logic              act_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
      idx_o <= '0;
      rem_q <= '0;
    end else if (issue_i) begin
      // new read preempts any burst in progress
      act_o <= 1'b1;
      idx_o <= '0;
      rem_q <= IDX_W'(rd_align_pkg::blen_last(int'(blen_code_i)));
    end else if (rem_q != '0) begin
      act_o <= 1'b1;
      idx_o <= idx_o + IDX_W'(1);
      rem_q <= rem_q - IDX_W'(1);
    end else begin
      act_o <= 1'b0;
      idx_o <= '0;
    end
  end
endmodule

// File: rtl/rd_delay_line.sv
module rd_delay_line #(
  parameter int W     = 4,
  parameter int DEPTH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [W-1:0]          din_i,
  output logic [DEPTH:0][W-1:0] taps_o
);
  assign taps_o[0] = din_i;

  for (genvar s = 1; s <= DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) taps_o[s] <= '0;
      else         taps_o[s] <= taps_o[s-1];
    end
  end
endmodule

// File: rtl/rd_cas_aligner.sv
module rd_cas_aligner #(
  parameter int BLEN_CODE_W = rd_align_pkg::BLEN_CODE_W,
  parameter int LAT_CODE_W  = rd_align_pkg::LAT_CODE_W,
  parameter int LAT_MIN     = rd_align_pkg::LAT_MIN,
  parameter int LAT_MAX     = rd_align_pkg::LAT_MAX,
  parameter int IDX_W       = (1 << BLEN_CODE_W) - 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_issue_i,
  input  logic [BLEN_CODE_W-1:0] blen_code_i,
  input  logic [LAT_CODE_W-1:0]  cas_code_i,
  output logic                   drive_en_o,
  output logic                   data_valid_o,
  output logic [IDX_W-1:0]       beat_idx_o,
  output logic                   lat_err_o
);
  localparam int DEPTH = LAT_MAX - 1;
  localparam int W     = IDX_W + 1;
  localparam int SEL_W = $clog2(DEPTH + 1);

  logic [LAT_CODE_W-1:0] lat;
  logic                  gen_act;
  logic [IDX_W-1:0]      gen_idx;
  logic [DEPTH:0][W-1:0] taps;
  logic [SEL_W-1:0]      vsel, lsel;
  logic [W-1:0]          vtap, ltap;

  rd_lat_decode #(
    .CODE_W (LAT_CODE_W),
    .LAT_MIN(LAT_MIN),
    .LAT_MAX(LAT_MAX)
  ) u_dec (
    .cas_code_i(cas_code_i),
    .lat_o     (lat),
    .err_o     (lat_err_o)
  );

  rd_burst_gen #(
    .CODE_W(BLEN_CODE_W),
    .IDX_W (IDX_W)
  ) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (rd_issue_i),
    .blen_code_i(blen_code_i),
    .act_o      (gen_act),
    .idx_o      (gen_idx)
  );

  rd_delay_line #(
    .W    (W),
    .DEPTH(DEPTH)
  ) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i ({gen_act, gen_idx}),
    .taps_o(taps)
  );

  // stage 0 is issue-aligned; valid sits lat-1 stages later, drive one ahead
  assign vsel = SEL_W'(int'(lat) - 1);
  assign lsel = SEL_W'(int'(lat) - 2);
  assign vtap = taps[vsel];
  assign ltap = taps[lsel];

  assign data_valid_o = vtap[W-1];
  assign beat_idx_o   = vtap[W-1] ? vtap[IDX_W-1:0] : '0;
  assign drive_en_o   = vtap[W-1] | ltap[W-1];
endmodule

// File: rtl/rd_cas_aligner_chk.sv
module rd_cas_aligner_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_issue_i,
  input logic [2:0]       cas_code_i,
  input logic             drive_en_o,
  input logic             data_valid_o,
  input logic [IDX_W-1:0] beat_idx_o
);
  // R2
  cl2_first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_issue_i && cas_code_i == 3'b010) |=> ##1 (data_valid_o && beat_idx_o == '0));

  // R3
  cl3_first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_issue_i && cas_code_i != 3'b010) |=> ##2 (data_valid_o && beat_idx_o == '0));

  // R6
  drive_covers_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> drive_en_o);

  // R6
  drive_leads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_valid_o) |-> $past(drive_en_o));

  // R5
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && $past(data_valid_o)) |->
      (beat_idx_o == $past(beat_idx_o) + IDX_W'(1) || beat_idx_o == '0));

  // R8
  drive_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_en_o) |-> $past(data_valid_o));
endmodule

bind rd_cas_aligner rd_cas_aligner_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_issue_i  (rd_issue_i),
  .cas_code_i  (cas_code_i),
  .drive_en_o  (drive_en_o),
  .data_valid_o(data_valid_o),
  .beat_idx_o  (beat_idx_o)
);

// File: tb/rd_cas_aligner_tb.sv
module rd_cas_aligner_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_issue_i = 1'b0;
  logic [1:0] blen_code_i = 2'b00;
  logic [2:0] cas_code_i = 3'b010;
  logic       drive_en_o, data_valid_o, lat_err_o;
  logic [2:0] beat_idx_o;

  int checks = 0;
  int fails  = 0;
  logic [63:0] iss;

  always #4 clk_i = ~clk_i;

  rd_cas_aligner u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_issue_i  (rd_issue_i),
    .blen_code_i (blen_code_i),
    .cas_code_i  (cas_code_i),
    .drive_en_o  (drive_en_o),
    .data_valid_o(data_valid_o),
    .beat_idx_o  (beat_idx_o),
    .lat_err_o   (lat_err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // latest strobe at or before edge t owns the beat
  function automatic void beat_at(input int t, input int bl, output bit a, output int k);
    a = 1'b0;
    k = 0;
    if (t < 0) return;
    for (int i = t; i >= 0 && i > t - 8; i--) begin
      if (iss[i]) begin
        if (t - i < bl) begin
          a = 1'b1;
          k = t - i;
        end
        return;
      end
    end
  endfunction

  task automatic run_pattern(input logic [31:0] pat, input int len, input logic [2:0] code,
                             input logic [1:0] bcode, input int lat, input string tag);
    bit va, la;
    int vk, lk;
    int bl = 1 << bcode;
    iss = '0;
    for (int i = 0; i < len; i++) iss[i] = pat[i];
    cas_code_i  = code;
    blen_code_i = bcode;
    for (int c = 0; c < len + 16; c++) begin
      rd_issue_i = (c < len) ? pat[c] : 1'b0;
      @(posedge clk_i);
      @(negedge clk_i);
      beat_at(c - (lat - 1), bl, va, vk);
      beat_at(c - (lat - 2), bl, la, lk);
      chk(data_valid_o == va, {tag, " valid"}, int'(data_valid_o), int'(va));
      if (va) chk(int'(beat_idx_o) == vk, {tag, " R5 beat_idx"}, int'(beat_idx_o), vk);
      chk(drive_en_o == (va | la), {tag, " R6 R8 drive"}, int'(drive_en_o), int'(va | la));
    end
  endtask

  task automatic t_reset();
    chk(drive_en_o == 1'b0, "R1 drive", int'(drive_en_o), 0);
    chk(data_valid_o == 1'b0, "R1 valid", int'(data_valid_o), 0);
    chk(beat_idx_o == 3'd0, "R1 idx", int'(beat_idx_o), 0);
    chk(lat_err_o == 1'b0, "R1 err", int'(lat_err_o), 0);
  endtask

  task automatic t_code_sweep();
    for (int c = 0; c < 8; c++) begin
      cas_code_i = 3'(c);
      #1;
      chk(lat_err_o == !(c == 2 || c == 3), "R4 err flag", int'(lat_err_o),
          int'(!(c == 2 || c == 3)));
      chk(drive_en_o == 1'b0, "R4 idle drive", int'(drive_en_o), 0);
    end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_code_sweep();
    run_pattern(32'h1, 1, 3'b010, 2'b00, 2, "R2 cl2 single");
    run_pattern(32'h1, 1, 3'b011, 2'b10, 3, "R3 cl3 bl4");
    run_pattern(32'h1, 1, 3'b101, 2'b01, 3, "R4 reserved bl2");
    run_pattern(32'h1, 1, 3'b010, 2'b11, 2, "R5 cl2 bl8");
    run_pattern(32'h3F, 6, 3'b011, 2'b10, 3, "R7 every cycle");
    run_pattern(32'h15, 6, 3'b010, 2'b01, 2, "R8 chained bl2");
    run_pattern(32'h11, 5, 3'b011, 2'b00, 3, "R6 spaced reads");
    run_pattern(32'h9, 4, 3'b010, 2'b10, 2, "R7 preempt bl4");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule